// File: doc/BRIEF.md
# Sprite Zero Hit Detector

This block raises the sprite-zero-hit status bit of a tile-and-sprite video renderer. While the picture is drawn, the pixel pipeline presents one pixel per enabled cycle: its column, the 2-bit pattern index from the background unit and the 2-bit pattern index from sprite output unit 0. The bit goes high at the first pixel of a frame where both indices are opaque, sprite zero is on the line being drawn, and no masking rule blocks the pixel. The CPU polls the bit to learn how far drawing has progressed.

Sprite evaluation works one line ahead, so it reports whether sprite zero will appear on the next line. The detector keeps its own copy of that report for the line now being drawn. It takes the copy at each line start, so the evaluation that runs during the current line cannot change the current answer. The bit stays set until the clear strobe at dot 1 of the pre-render line. Reading the status register does not clear it.

Top module: `sprite0_hit_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), hit_flag is 0 and the detector treats sprite zero as absent from the current line.
- R2: A pixel is opaque when its 2-bit pattern index is non-zero. Index 0 is transparent, and any of 1, 2 or 3 counts as opaque. A hit needs both bg_idx and spr0_idx to be opaque.
- R3: A qualifying pixel presented with pix_en high sets hit_flag at that clock edge, so hit_flag reads 1 from the next cycle. A pixel with pix_en low never causes a hit.
- R4: No hit occurs while bg_render_en or spr_render_en is 0.
- R5: At columns 0 to 7, a hit is possible only when both bg_left_en and spr_left_en are 1. From column 8 onward these two inputs have no effect.
- R6: No hit occurs at column 255, the last column. Column 254 can hit.
- R7: The current-line sprite-zero flag is loaded from zero_next_line at a clock edge where line_start is 1, and takes effect from the next pixel. Changes on zero_next_line at any other time do not affect detection on the current line.
- R8: Once set, hit_flag stays 1 through any further pixels until frame_clr is 1 at a clock edge. hit_flag then reads 0 from the next cycle.
- R9: When frame_clr and a qualifying pixel arrive at the same edge, the clear wins and hit_flag reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | A pixel is being drawn this cycle |
| pix_x | input | 8 | Column of the current pixel |
| frame_clr | input | 1 | Pre-render line, dot 1 strobe; clears the hit bit |
| line_start | input | 1 | Scanline-start strobe; loads the current-line flag |
| zero_next_line | input | 1 | From sprite evaluation: sprite zero is in range for the next line |
| bg_render_en | input | 1 | Background rendering enable |
| spr_render_en | input | 1 | Sprite rendering enable |
| bg_left_en | input | 1 | Background shown in columns 0 to 7 |
| spr_left_en | input | 1 | Sprites shown in columns 0 to 7 |
| bg_idx | input | 2 | Background pattern index of the pixel |
| spr0_idx | input | 2 | Pattern index from sprite output unit 0 |
| hit_flag | output | 1 | Sprite-zero-hit status bit (status bit 6) |

## Verification
The bench probes the edges of the masking rules. It checks column 7 against column 8 with one left enable off, column 254 against column 255, and each non-zero index value against index 0. A design with an off-by-one clip window or last-column compare would hit at column 7 or 255, or miss column 8 or 254. It raises zero_next_line without a line start, then drops it in mid-line after a line start. A design that reads the evaluation flag directly would hit in the first case and miss in the second. It also drives the frame clear at the same edge as a qualifying pixel, and feeds further pixels after a hit. A design with the wrong priority, or with a bit that is not sticky, would end up holding the wrong value.

// File: rtl/sprite0_hit_pkg.sv
// Package: shared widths and the per-pixel record used by the detector.
// Assumes a one-pixel-per-cycle pipeline with 2-bit pattern indices.
package sprite0_hit_pkg;
    localparam int unsigned COL_W   = 8;
    localparam int unsigned IDX_W   = 2;
    localparam int unsigned CLIP_W  = 8;

    typedef struct packed {
        logic             valid;
        logic [COL_W-1:0] col;
        logic [IDX_W-1:0] bg;
        logic [IDX_W-1:0] spr;
    } pixel_t;
endpackage

// File: rtl/sprite0_pixel_qual.sv
// Module: decides whether the presented pixel may register a hit,
// ignoring whether sprite zero is on the line. Assumes the clip window
// starts at column 0 and the last column is the all-ones column value.
module sprite0_pixel_qual #(
    parameter int unsigned COL_W  = 8,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned CLIP_W = 8
) (
    input  logic             pix_en,
    input  logic [COL_W-1:0] pix_x,
    input  logic             bg_render_en,
    input  logic             spr_render_en,
    input  logic             bg_left_en,
    input  logic             spr_left_en,
    input  logic [IDX_W-1:0] bg_idx,
    input  logic [IDX_W-1:0] spr0_idx,
    output logic             pix_ok
);
    localparam logic [COL_W-1:0] LAST_COL = {COL_W{1'b1}};

    logic in_clip;
    logic opaque_both;
    logic col_ok;

    // purpose: flag columns inside the left clip window (none if CLIP_W is 0)
    generate
        if (CLIP_W == 0) begin : g_noclip
            assign in_clip = 1'b0;
        end else begin : g_clip
            localparam logic [COL_W:0] CLIP_END = (COL_W+1)'(CLIP_W);
            assign in_clip = ({1'b0, pix_x} < CLIP_END);
        end
    endgenerate

    // purpose: combine opacity, enables and column masks
    always_comb begin
        opaque_both = (|bg_idx) && (|spr0_idx);
        col_ok      = (pix_x != LAST_COL) &&
                      (!in_clip || (bg_left_en && spr_left_en));
        pix_ok      = pix_en && opaque_both && col_ok &&
                      bg_render_en && spr_render_en;
    end
endmodule

// File: rtl/sprite0_line_track.sv
// Module: holds the current-line sprite-zero flag, copied from the
// evaluation (next-line) flag on the line-start strobe only.
// Assumes line_start pulses once before the first pixel of each line.
module sprite0_line_track (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic zero_next_line,
    output logic zero_cur_line
);
    // purpose: load the current-line copy at line start, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_cur_line <= 1'b0;
        else if (line_start)
            zero_cur_line <= zero_next_line;
    end

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (zero_cur_line == $past(zero_next_line)));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && $past(rst_n)) |=> $stable(zero_cur_line));
endmodule

// File: rtl/sprite0_hit_flag.sv
// Module: sticky status bit, set by a hit strobe and cleared by the
// frame clear strobe; the clear takes priority. Assumes both inputs
// are single-cycle qualified strobes.
module sprite0_hit_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    // purpose: sticky set, clear wins on collision
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (clr_req)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
    end

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !flag);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && set_req) |=> !flag);
endmodule

// File: rtl/sprite0_hit_top.sv
// Module: sprite-zero-hit detector top. Qualifies each pixel, gates it
// with the current-line sprite-zero flag and drives the sticky status bit.
// Assumes one pixel per enabled cycle and strobes from the frame timer.
module sprite0_hit_top
    import sprite0_hit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [COL_W-1:0] pix_x,
    input  logic             frame_clr,
    input  logic             line_start,
    input  logic             zero_next_line,
    input  logic             bg_render_en,
    input  logic             spr_render_en,
    input  logic             bg_left_en,
    input  logic             spr_left_en,
    input  logic [IDX_W-1:0] bg_idx,
    input  logic [IDX_W-1:0] spr0_idx,
    output logic             hit_flag
);
    pixel_t px;
    logic   pix_ok;
    logic   zero_cur;
    logic   hit_now;

    // purpose: gather the pixel fields into one record
    always_comb begin
        px.valid = pix_en;
        px.col   = pix_x;
        px.bg    = bg_idx;
        px.spr   = spr0_idx;
    end

    sprite0_pixel_qual #(
        .COL_W (COL_W),
        .IDX_W (IDX_W),
        .CLIP_W(CLIP_W)
    ) u_qual (
        .pix_en       (px.valid),
        .pix_x        (px.col),
        .bg_render_en (bg_render_en),
        .spr_render_en(spr_render_en),
        .bg_left_en   (bg_left_en),
        .spr_left_en  (spr_left_en),
        .bg_idx       (px.bg),
        .spr0_idx     (px.spr),
        .pix_ok       (pix_ok)
    );

    sprite0_line_track u_line (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start    (line_start),
        .zero_next_line(zero_next_line),
        .zero_cur_line (zero_cur)
    );

    // purpose: a hit needs a qualified pixel while sprite zero is on this line
    always_comb hit_now = pix_ok && zero_cur;

    sprite0_hit_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(hit_now),
        .clr_req(frame_clr),
        .flag   (hit_flag)
    );

    assert_rise_opaque_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> ($past(bg_idx) != '0 && $past(spr0_idx) != '0));
    assert_rise_pix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> $past(pix_en));
    assert_rise_render_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> ($past(bg_render_en) && $past(spr_render_en)));
    assert_no_last_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> ($past(pix_x) != {COL_W{1'b1}}));
endmodule

// File: tb/tb_sprite0_hit_top.sv
module tb_sprite0_hit_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic [7:0] pix_x = '0;
    logic       frame_clr = 1'b0;
    logic       line_start = 1'b0;
    logic       zero_next_line = 1'b0;
    logic       bg_render_en = 1'b1;
    logic       spr_render_en = 1'b1;
    logic       bg_left_en = 1'b1;
    logic       spr_left_en = 1'b1;
    logic [1:0] bg_idx = '0;
    logic [1:0] spr0_idx = '0;
    logic       hit_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sprite0_hit_top dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_x(pix_x),
        .frame_clr(frame_clr), .line_start(line_start),
        .zero_next_line(zero_next_line), .bg_render_en(bg_render_en),
        .spr_render_en(spr_render_en), .bg_left_en(bg_left_en),
        .spr_left_en(spr_left_en), .bg_idx(bg_idx), .spr0_idx(spr0_idx),
        .hit_flag(hit_flag)
    );

    task automatic chk(input logic exp, input string req);
        n_chk++;
        if (hit_flag !== exp) begin
            n_fail++;
            $display("FAIL %s: hit_flag actual %b expected %b", req, hit_flag, exp);
        end
    endtask

    task automatic px(input logic [7:0] x, input logic [1:0] b, input logic [1:0] s);
        @(negedge clk);
        pix_en = 1'b1; pix_x = x; bg_idx = b; spr0_idx = s;
        @(negedge clk);
        pix_en = 1'b0; bg_idx = '0; spr0_idx = '0;
    endtask

    task automatic new_frame();
        @(negedge clk); frame_clr = 1'b1;
        @(negedge clk); frame_clr = 1'b0;
    endtask

    task automatic start_line(input logic zn);
        @(negedge clk); zero_next_line = zn; line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b0, "R1 reset value");
        px(8'd100, 2'd3, 2'd3);
        chk(1'b0, "R1 sprite zero absent after reset");
    endtask

    task automatic t_current_line();
        new_frame();
        @(negedge clk); zero_next_line = 1'b1;
        px(8'd50, 2'd1, 2'd1);
        chk(1'b0, "R7 next-line flag without line start");
        start_line(1'b1);
        @(negedge clk); zero_next_line = 1'b0;
        px(8'd50, 2'd1, 2'd1);
        chk(1'b1, "R7 current-line flag held after eval drops");
        new_frame();
        start_line(1'b0);
        @(negedge clk); zero_next_line = 1'b1;
        px(8'd60, 2'd2, 2'd2);
        chk(1'b0, "R7 line start with flag low");
    endtask

    task automatic t_opacity();
        new_frame();
        start_line(1'b1);
        px(8'd40, 2'd0, 2'd3);
        chk(1'b0, "R2 transparent background");
        px(8'd41, 2'd3, 2'd0);
        chk(1'b0, "R2 transparent sprite");
        for (int v = 1; v < 4; v++) begin
            new_frame();
            px(8'd42, 2'(v), 2'(4 - v));
            chk(1'b1, "R2 opaque index pair");
        end
        new_frame();
        @(negedge clk); pix_x = 8'd43; bg_idx = 2'd3; spr0_idx = 2'd3;
        @(negedge clk); bg_idx = '0; spr0_idx = '0;
        chk(1'b0, "R3 pix_en low");
        px(8'd43, 2'd1, 2'd2);
        chk(1'b1, "R3 hit next cycle");
    endtask

    task automatic t_render();
        new_frame();
        bg_render_en = 1'b0;
        px(8'd90, 2'd3, 2'd3);
        chk(1'b0, "R4 background off");
        bg_render_en = 1'b1; spr_render_en = 1'b0;
        px(8'd90, 2'd3, 2'd3);
        chk(1'b0, "R4 sprites off");
        spr_render_en = 1'b1;
    endtask

    task automatic t_clip();
        new_frame();
        bg_left_en = 1'b0;
        px(8'd7, 2'd1, 2'd1);
        chk(1'b0, "R5 column 7 bg clip");
        px(8'd0, 2'd1, 2'd1);
        chk(1'b0, "R5 column 0 bg clip");
        bg_left_en = 1'b1; spr_left_en = 1'b0;
        px(8'd3, 2'd1, 2'd1);
        chk(1'b0, "R5 column 3 sprite clip");
        px(8'd8, 2'd1, 2'd1);
        chk(1'b1, "R5 column 8 outside window");
        spr_left_en = 1'b1;
        new_frame();
        px(8'd0, 2'd2, 2'd1);
        chk(1'b1, "R5 column 0 both enables on");
    endtask

    task automatic t_last_col();
        new_frame();
        px(8'd255, 2'd3, 2'd3);
        chk(1'b0, "R6 column 255 blocked");
        px(8'd254, 2'd3, 2'd3);
        chk(1'b1, "R6 column 254 hits");
    endtask

    task automatic t_sticky();
        px(8'd10, 2'd0, 2'd0);
        chk(1'b1, "R8 stays set on transparent pixel");
        start_line(1'b0);
        px(8'd11, 2'd3, 2'd3);
        chk(1'b1, "R8 stays set across lines");
        new_frame();
        chk(1'b0, "R8 frame clear");
        start_line(1'b1);
        @(negedge clk);
        pix_en = 1'b1; pix_x = 8'd70; bg_idx = 2'd2; spr0_idx = 2'd2; frame_clr = 1'b1;
        @(negedge clk);
        pix_en = 1'b0; bg_idx = '0; spr0_idx = '0; frame_clr = 1'b0;
        chk(1'b0, "R9 clear wins over hit");
        @(negedge clk);
        chk(1'b0, "R9 still clear after collision");
    endtask

    initial begin
        t_reset();
        t_current_line();
        t_opacity();
        t_render();
        t_clip();
        t_last_col();
        t_sticky();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule